// File: doc/BRIEF.md
# Late-Split Load-Op Dispatcher

This block sits after register renaming and feeds two reservation stations: one for memory operations and one for the integer ALU. Each renamed instruction arriving on its input lanes is a plain ALU operation, a plain load, or a fused load-op that already owns a single reorder-buffer entry. The fused form is split only here, at dispatch. Its load half, which writes a short-lived temporary register, leaves in one dispatch group. Its ALU half, which reads that temporary in place of the memory operand, leaves in a later group. Both halves carry the same reorder-buffer tag.

Each cycle the block builds a dispatch group of at most `DISP_W` micro-ops. A pending ALU half goes first. Instructions from the input lanes fill the remaining slots in program order. A fused load-op closes the group it joins, so that no younger instruction can overtake its ALU half. Temporaries come from a small dedicated pool. A temporary is taken when its fused instruction is accepted and given back when the ALU station reports that the reading micro-op has issued. The group waits in an output register until every station that receives part of it is ready. While it waits, no new input is accepted.

Top module: `ldop_crack_dispatch`

## Requirements
- R1: The input kind code selects the split. 2'b00 gives one ALU micro-op carrying src0..src2 and dst. 2'b01 gives one load micro-op with the base register in src0, dst as destination, and src1 and src2 zero. 2'b10 (fused) gives a load micro-op (base in src0, dst zero, temp-write set) followed by an ALU micro-op (src0..src2, dst, temp-read set). 2'b11 is handled like 2'b00. Every micro-op carries its instruction's ROB tag.
- R2: Taken over all fired groups, with slot 0 read before slot 1, the micro-ops appear in program order.
- R3: Valid slots are contiguous from slot 0. A fused instruction's load half is always the last valid slot of its group. Its ALU half is always in slot 0 of a later group, so it fires at least one cycle after the load half.
- R4: When the output register is empty or fires, the block accepts lanes in order for as long as slots remain, stopping after a fused instruction. `in_take` gives the number of lanes accepted, and it never exceeds the number of valid lanes.
- R5: A fused instruction takes the lowest-numbered free temporary at acceptance. A temporary that is in use is never handed out again. The ALU half carries the same temporary index as its load half.
- R6: When no temporary is free, a fused lane is not accepted, and no lane after it is accepted either. Plain lanes ahead of it are still accepted.
- R7: A pulse on `tmp_rel_valid` returns temporary `tmp_rel_id` to the pool, and that temporary can be allocated from the next cycle on.
- R8: A group fires only when `mem_ready` is high (if the group holds a load) and `alu_ready` is high (if it holds an ALU micro-op). Otherwise the group stays unchanged and `in_take` is 0.
- R9: `mem_valid` is high exactly when the held group holds a load micro-op. `alu_valid` is high exactly when it holds an ALU micro-op.
- R10: After reset the output group is empty, both station valids are low, no ALU half is pending, and all temporaries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | DISP_W | Lane valid, lane 0 oldest, contiguous |
| in_kind | input | DISP_W x 2 | Instruction kind code per lane |
| in_rob | input | DISP_W x ROB_W | ROB tag per lane |
| in_base | input | DISP_W x AREG_W | Address base register per lane |
| in_src0 | input | DISP_W x AREG_W | First ALU source per lane |
| in_src1 | input | DISP_W x AREG_W | Second ALU source per lane |
| in_src2 | input | DISP_W x AREG_W | Third ALU source per lane |
| in_dst | input | DISP_W x AREG_W | Architectural destination per lane |
| in_take | output | TAKE_W | Number of lanes accepted this cycle |
| mem_ready | input | 1 | Memory station can accept |
| alu_ready | input | 1 | ALU station can accept |
| mem_valid | output | 1 | Group holds a load micro-op |
| alu_valid | output | 1 | Group holds an ALU micro-op |
| slot_valid | output | DISP_W | Slot holds a micro-op |
| slot_is_load | output | DISP_W | Slot goes to the memory station |
| slot_rob | output | DISP_W x ROB_W | ROB tag per slot |
| slot_src0 | output | DISP_W x AREG_W | Source 0 (base for loads) |
| slot_src1 | output | DISP_W x AREG_W | Source 1 |
| slot_src2 | output | DISP_W x AREG_W | Source 2 |
| slot_dst | output | DISP_W x AREG_W | Architectural destination |
| slot_tmp_wr | output | DISP_W | Micro-op writes the temporary |
| slot_tmp_rd | output | DISP_W | Micro-op reads the temporary |
| slot_tmp_id | output | DISP_W x TMP_W | Temporary index |
| tmp_rel_valid | input | 1 | Release a temporary |
| tmp_rel_id | input | TMP_W | Temporary being released |

## Verification
The embedded assertions watch the shape of each group on every cycle: slots stay contiguous, a load half ends its group, an ALU half sits only in slot 0, and a waiting group holds still while accepting nothing. They also check that a temporary read by a held ALU half is marked busy and that only busy temporaries are released. Other behaviours need whole scenarios in the bench: program order across groups, the lowest-free choice of temporary after mixed releases, the maximum lane take for given slot occupancy, and the pool-exhaustion stall that still admits older plain lanes.

// File: rtl/ldop_pkg.sv
package ldop_pkg;
  localparam int ROB_W  = 6;
  localparam int AREG_W = 5;
  localparam int TMP_N  = 8;
  localparam int TMP_W  = (TMP_N > 1) ? $clog2(TMP_N) : 1;

  typedef enum logic [1:0] {
    K_ALU  = 2'b00,
    K_LOAD = 2'b01,
    K_LDOP = 2'b10,
    K_RSVD = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [ROB_W-1:0]    rob;
    logic [AREG_W-1:0]   base;
    logic [AREG_W-1:0]   src0;
    logic [AREG_W-1:0]   src1;
    logic [AREG_W-1:0]   src2;
    logic [AREG_W-1:0]   dst;
  } inst_t;

  typedef struct packed {
    logic                is_load;
    logic [ROB_W-1:0]    rob;
    logic [AREG_W-1:0]   src0;
    logic [AREG_W-1:0]   src1;
    logic [AREG_W-1:0]   src2;
    logic [AREG_W-1:0]   dst;
    logic                tmp_wr;
    logic                tmp_rd;
    logic [TMP_W-1:0]    tmp_id;
  } uop_t;
endpackage

// File: rtl/ldop_tmp_pool.sv
module ldop_tmp_pool
  import ldop_pkg::*;
#(
  parameter int N = TMP_N,
  parameter int W = TMP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         alloc_en,
  input  logic         rel_valid,
  input  logic [W-1:0] rel_id,
  output logic         avail,
  output logic [W-1:0] alloc_id,
  output logic [N-1:0] busy_o
);
  logic [N-1:0] busy_q, busy_d;

  // lowest-numbered free entry
  always_comb begin
    avail    = 1'b0;
    alloc_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        avail    = 1'b1;
        alloc_id = W'(i);
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (alloc_en)  busy_d[alloc_id] = 1'b1;
    if (rel_valid) busy_d[rel_id]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  // R6
  alloc_avail_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> avail);

  // R7
  rel_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> busy_q[rel_id]);

  // R7
  rel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rel_valid |=> !busy_q[$past(rel_id)]);

  // R5
  alloc_mark_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> busy_q[$past(alloc_id)]);
endmodule

// File: rtl/ldop_packer.sv
module ldop_packer
  import ldop_pkg::*;
#(
  parameter int DISP_W = 2,
  parameter int TAKE_W = $clog2(DISP_W + 1)
) (
  input  logic                   pend_valid,
  input  uop_t                   pend,
  input  logic [DISP_W-1:0]      in_valid,
  input  inst_t [DISP_W-1:0]     inst,
  input  logic                   tmp_avail,
  input  logic [TMP_W-1:0]       tmp_id,
  output uop_t [DISP_W-1:0]      slot_nxt,
  output logic [DISP_W-1:0]      vld_nxt,
  output logic [TAKE_W-1:0]      take,
  output logic                   alloc_req,
  output logic                   np_valid,
  output uop_t                   np
);
  localparam int IDX_W = (DISP_W > 1) ? $clog2(DISP_W) : 1;

  logic [TAKE_W-1:0] cnt;
  logic              stop;
  uop_t              cand;
  logic              blocked;

  always_comb begin
    slot_nxt  = '0;
    vld_nxt   = '0;
    take      = '0;
    alloc_req = 1'b0;
    np_valid  = 1'b0;
    np        = '0;
    cnt       = '0;
    stop      = 1'b0;
    cand      = '0;
    blocked   = 1'b0;
    if (pend_valid) begin
      slot_nxt[0] = pend;
      vld_nxt[0]  = 1'b1;
      cnt         = TAKE_W'(1);
    end
    for (int l = 0; l < DISP_W; l++) begin
      if (!stop && in_valid[l] && (cnt < TAKE_W'(DISP_W))) begin
        cand      = '0;
        blocked   = 1'b0;
        cand.rob  = inst[l].rob;
        case (inst[l].kind)
          K_LOAD: begin
            cand.is_load = 1'b1;
            cand.src0    = inst[l].base;
            cand.dst     = inst[l].dst;
          end
          K_LDOP: begin
            if (tmp_avail) begin
              cand.is_load = 1'b1;
              cand.src0    = inst[l].base;
              cand.tmp_wr  = 1'b1;
              cand.tmp_id  = tmp_id;
              alloc_req    = 1'b1;
              np_valid     = 1'b1;
              np.rob       = inst[l].rob;
              np.src0      = inst[l].src0;
              np.src1      = inst[l].src1;
              np.src2      = inst[l].src2;
              np.dst       = inst[l].dst;
              np.tmp_rd    = 1'b1;
              np.tmp_id    = tmp_id;
            end else begin
              blocked = 1'b1;
            end
          end
          default: begin
            cand.src0 = inst[l].src0;
            cand.src1 = inst[l].src1;
            cand.src2 = inst[l].src2;
            cand.dst  = inst[l].dst;
          end
        endcase
        if (blocked) begin
          stop = 1'b1;
        end else begin
          slot_nxt[cnt[IDX_W-1:0]] = cand;
          vld_nxt[cnt[IDX_W-1:0]]  = 1'b1;
          cnt  = cnt + TAKE_W'(1);
          take = take + TAKE_W'(1);
          if (inst[l].kind == K_LDOP) stop = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldop_group_stage.sv
module ldop_group_stage
  import ldop_pkg::*;
#(
  parameter int DISP_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [DISP_W-1:0]   vld_nxt,
  input  uop_t [DISP_W-1:0]   slot_nxt,
  input  logic                np_valid,
  input  uop_t                np,
  output logic [DISP_W-1:0]   slot_vld,
  output uop_t [DISP_W-1:0]   slots,
  output logic                mem_v,
  output logic                alu_v,
  output logic                pend_valid,
  output uop_t                pend
);
  logic [DISP_W-1:0] ld_bits;

  always_comb begin
    for (int s = 0; s < DISP_W; s++) ld_bits[s] = slot_nxt[s].is_load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld   <= '0;
      slots      <= '0;
      mem_v      <= 1'b0;
      alu_v      <= 1'b0;
      pend_valid <= 1'b0;
      pend       <= '0;
    end else if (load_en) begin
      slot_vld   <= vld_nxt;
      slots      <= slot_nxt;
      mem_v      <= |(vld_nxt & ld_bits);
      alu_v      <= |(vld_nxt & ~ld_bits);
      pend_valid <= np_valid;
      pend       <= np;
    end
  end
endmodule

// File: rtl/ldop_crack_dispatch.sv
module ldop_crack_dispatch
  import ldop_pkg::*;
#(
  parameter int DISP_W = 2,
  localparam int TAKE_W = $clog2(DISP_W + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [DISP_W-1:0]              in_valid,
  input  logic [DISP_W-1:0][1:0]         in_kind,
  input  logic [DISP_W-1:0][ROB_W-1:0]   in_rob,
  input  logic [DISP_W-1:0][AREG_W-1:0]  in_base,
  input  logic [DISP_W-1:0][AREG_W-1:0]  in_src0,
  input  logic [DISP_W-1:0][AREG_W-1:0]  in_src1,
  input  logic [DISP_W-1:0][AREG_W-1:0]  in_src2,
  input  logic [DISP_W-1:0][AREG_W-1:0]  in_dst,
  output logic [TAKE_W-1:0]              in_take,
  input  logic                           mem_ready,
  input  logic                           alu_ready,
  output logic                           mem_valid,
  output logic                           alu_valid,
  output logic [DISP_W-1:0]              slot_valid,
  output logic [DISP_W-1:0]              slot_is_load,
  output logic [DISP_W-1:0][ROB_W-1:0]   slot_rob,
  output logic [DISP_W-1:0][AREG_W-1:0]  slot_src0,
  output logic [DISP_W-1:0][AREG_W-1:0]  slot_src1,
  output logic [DISP_W-1:0][AREG_W-1:0]  slot_src2,
  output logic [DISP_W-1:0][AREG_W-1:0]  slot_dst,
  output logic [DISP_W-1:0]              slot_tmp_wr,
  output logic [DISP_W-1:0]              slot_tmp_rd,
  output logic [DISP_W-1:0][TMP_W-1:0]   slot_tmp_id,
  input  logic                           tmp_rel_valid,
  input  logic [TMP_W-1:0]               tmp_rel_id
);
  inst_t [DISP_W-1:0] inst;
  uop_t  [DISP_W-1:0] slot_nxt, slots;
  logic  [DISP_W-1:0] vld_nxt;
  logic  [TAKE_W-1:0] take;
  logic               alloc_req, np_valid, pend_valid;
  uop_t               np, pend;
  logic               tmp_avail;
  logic [TMP_W-1:0]   tmp_id;
  logic [TMP_N-1:0]   tmp_busy;
  logic               fire, load_en;

  for (genvar l = 0; l < DISP_W; l++) begin : g_lane
    assign inst[l].kind = kind_e'(in_kind[l]);
    assign inst[l].rob  = in_rob[l];
    assign inst[l].base = in_base[l];
    assign inst[l].src0 = in_src0[l];
    assign inst[l].src1 = in_src1[l];
    assign inst[l].src2 = in_src2[l];
    assign inst[l].dst  = in_dst[l];
  end

  assign fire    = (|slot_valid) && (!mem_valid || mem_ready) && (!alu_valid || alu_ready);
  assign load_en = !(|slot_valid) || fire;
  assign in_take = load_en ? take : '0;

  ldop_tmp_pool #(.N(TMP_N), .W(TMP_W)) pool_i (
    .clk(clk), .rst(rst),
    .alloc_en(load_en && alloc_req),
    .rel_valid(tmp_rel_valid), .rel_id(tmp_rel_id),
    .avail(tmp_avail), .alloc_id(tmp_id), .busy_o(tmp_busy)
  );

  ldop_packer #(.DISP_W(DISP_W), .TAKE_W(TAKE_W)) pack_i (
    .pend_valid(pend_valid), .pend(pend),
    .in_valid(in_valid), .inst(inst),
    .tmp_avail(tmp_avail), .tmp_id(tmp_id),
    .slot_nxt(slot_nxt), .vld_nxt(vld_nxt), .take(take),
    .alloc_req(alloc_req), .np_valid(np_valid), .np(np)
  );

  ldop_group_stage #(.DISP_W(DISP_W)) grp_i (
    .clk(clk), .rst(rst), .load_en(load_en),
    .vld_nxt(vld_nxt), .slot_nxt(slot_nxt),
    .np_valid(np_valid), .np(np),
    .slot_vld(slot_valid), .slots(slots),
    .mem_v(mem_valid), .alu_v(alu_valid),
    .pend_valid(pend_valid), .pend(pend)
  );

  for (genvar s = 0; s < DISP_W; s++) begin : g_slot
    assign slot_is_load[s] = slots[s].is_load;
    assign slot_rob[s]     = slots[s].rob;
    assign slot_src0[s]    = slots[s].src0;
    assign slot_src1[s]    = slots[s].src1;
    assign slot_src2[s]    = slots[s].src2;
    assign slot_dst[s]     = slots[s].dst;
    assign slot_tmp_wr[s]  = slots[s].tmp_wr;
    assign slot_tmp_rd[s]  = slots[s].tmp_rd;
    assign slot_tmp_id[s]  = slots[s].tmp_id;

    if (s > 0) begin : g_upper
      // R3
      contig_chk: assert property (@(posedge clk) disable iff (rst)
        slot_valid[s] |-> slot_valid[s-1]);
      // R3
      half_slot0_chk: assert property (@(posedge clk) disable iff (rst)
        slot_valid[s] |-> !slots[s].tmp_rd);
    end
    if (s < DISP_W - 1) begin : g_lower
      // R3
      fused_last_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[s] && slots[s].tmp_wr) |-> !slot_valid[s+1]);
    end
  end

  // R8
  hold_group_chk: assert property (@(posedge clk) disable iff (rst)
    ((|slot_valid) && !fire) |=> ($stable(slot_valid) && $stable(slots)));

  // R8
  take_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    ((|slot_valid) && !fire) |-> (in_take == '0));

  // R4
  take_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(in_take) <= $countones(in_valid));

  // R5
  half_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid[0] && slots[0].tmp_rd) |-> tmp_busy[slots[0].tmp_id]);

  // R5
  pend_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> tmp_busy[pend.tmp_id]);

  // R9
  station_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid || alu_valid) |-> (|slot_valid));
endmodule

// File: tb/ldop_crack_dispatch_tb_top.sv
module ldop_crack_dispatch_tb_top;
  import ldop_pkg::*;
  localparam int CLK_P  = 10;
  localparam int DW     = 2;
  localparam int TW     = $clog2(DW + 1);
  localparam int NI     = 2000;
  localparam int NU     = 4000;
  localparam int WD_LIM = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic [DW-1:0] in_valid;
  logic [DW-1:0][1:0] in_kind;
  logic [DW-1:0][ROB_W-1:0] in_rob;
  logic [DW-1:0][AREG_W-1:0] in_base, in_src0, in_src1, in_src2, in_dst;
  logic [TW-1:0] in_take;
  logic mem_ready, alu_ready, mem_valid, alu_valid;
  logic [DW-1:0] slot_valid, slot_is_load, slot_tmp_wr, slot_tmp_rd;
  logic [DW-1:0][ROB_W-1:0] slot_rob;
  logic [DW-1:0][AREG_W-1:0] slot_src0, slot_src1, slot_src2, slot_dst;
  logic [DW-1:0][TMP_W-1:0] slot_tmp_id;
  logic tmp_rel_valid;
  logic [TMP_W-1:0] tmp_rel_id;

  always #(CLK_P/2) clk = ~clk;

  ldop_crack_dispatch #(.DISP_W(DW)) dut_i (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  // program
  logic [1:0] p_kind [NI];
  logic [ROB_W-1:0] p_rob [NI];
  logic [AREG_W-1:0] p_base [NI], p_s0 [NI], p_s1 [NI], p_s2 [NI], p_dst [NI];
  int p_uop [NI], p_ldcyc [NI];
  int p_len = 0, head = 0;
  // expected micro-ops
  logic e_ld [NU], e_wr [NU], e_rd [NU];
  logic [ROB_W-1:0] e_rob [NU];
  logic [AREG_W-1:0] e_s0 [NU], e_s1 [NU], e_s2 [NU], e_dst [NU];
  logic [TMP_W-1:0] e_tmp [NU];
  int e_inst [NU];
  int e_len = 0, fptr = 0;
  logic [ROB_W-1:0] rob_ctr = '0;
  // temporary model
  logic [TMP_N-1:0] m_busy = '0, live = '0;
  logic [TMP_W-1:0] rq [64];
  int rq_h = 0, rq_t = 0;
  // modes
  bit rdy_rand = 0, f_mem = 1, f_alu = 1, rel_en = 1, lane_rand = 0;
  int last_take = 0, ld_fires = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic put_uop(input logic ld, input logic [AREG_W-1:0] s0, s1, s2, d,
                         input logic wr, rd, input int ii);
    e_ld[e_len] = ld; e_rob[e_len] = p_rob[ii];
    e_s0[e_len] = s0; e_s1[e_len] = s1; e_s2[e_len] = s2; e_dst[e_len] = d;
    e_wr[e_len] = wr; e_rd[e_len] = rd; e_tmp[e_len] = '0; e_inst[e_len] = ii;
    e_len++;
  endtask

  // R1 expected split by kind code
  task automatic add_inst(input logic [1:0] k);
    int i = p_len;
    p_kind[i] = k; p_rob[i] = rob_ctr; rob_ctr = rob_ctr + 1'b1;
    p_base[i] = AREG_W'($urandom); p_s0[i] = AREG_W'($urandom);
    p_s1[i] = AREG_W'($urandom); p_s2[i] = AREG_W'($urandom);
    p_dst[i] = AREG_W'($urandom);
    p_uop[i] = e_len;
    case (k)
      2'b01: put_uop(1'b1, p_base[i], '0, '0, p_dst[i], 1'b0, 1'b0, i);
      2'b10: begin
        put_uop(1'b1, p_base[i], '0, '0, '0, 1'b1, 1'b0, i);
        put_uop(1'b0, p_s0[i], p_s1[i], p_s2[i], p_dst[i], 1'b0, 1'b1, i);
      end
      default: put_uop(1'b0, p_s0[i], p_s1[i], p_s2[i], p_dst[i], 1'b0, 1'b0, i);
    endcase
    p_len++;
  endtask

  function automatic int lowest_free(input logic [TMP_N-1:0] b);
    for (int i = 0; i < TMP_N; i++) if (!b[i]) return i;
    return -1;
  endfunction

  task automatic step();
    int nl, tk, rel;
    logic fire;
    @(negedge clk);
    cyc++;
    mem_ready = rdy_rand ? (($urandom % 4) != 0) : f_mem;
    alu_ready = rdy_rand ? (($urandom % 4) != 0) : f_alu;
    rel = -1;
    tmp_rel_valid = 1'b0; tmp_rel_id = '0;
    if (rel_en && rq_h != rq_t && (($urandom % 2) == 0 || !lane_rand)) begin
      rel = int'(rq[rq_h % 64]); rq_h++;
      tmp_rel_valid = 1'b1; tmp_rel_id = TMP_W'(rel);
    end
    nl = lane_rand ? int'($urandom % (DW + 1)) : DW;
    in_valid = '0; in_kind = '0; in_rob = '0; in_base = '0;
    in_src0 = '0; in_src1 = '0; in_src2 = '0; in_dst = '0;
    for (int l = 0; l < DW; l++) begin
      if (l < nl && head + l < p_len) begin
        in_valid[l] = 1'b1; in_kind[l] = p_kind[head+l]; in_rob[l] = p_rob[head+l];
        in_base[l] = p_base[head+l]; in_src0[l] = p_s0[head+l];
        in_src1[l] = p_s1[head+l]; in_src2[l] = p_s2[head+l]; in_dst[l] = p_dst[head+l];
      end
    end
    #1;
    fire = (|slot_valid) && (!mem_valid || mem_ready) && (!alu_valid || alu_ready);
    if (fire) begin
      for (int s = 0; s < DW; s++) begin
        if (slot_valid[s]) begin
          if (fptr >= e_len) begin
            chk(1'b0, "R2 extra micro-op", fptr, e_len);
          end else begin
            int ii = e_inst[fptr];
            // R1 R2 content and order
            chk(slot_is_load[s] == e_ld[fptr] && slot_rob[s] == e_rob[fptr] &&
                slot_src0[s] == e_s0[fptr] && slot_src1[s] == e_s1[fptr] &&
                slot_src2[s] == e_s2[fptr] && slot_dst[s] == e_dst[fptr] &&
                slot_tmp_wr[s] == e_wr[fptr] && slot_tmp_rd[s] == e_rd[fptr],
                "R1/R2 micro-op fields", int'(slot_rob[s]), int'(e_rob[fptr]));
            if (e_wr[fptr] || e_rd[fptr])
              chk(slot_tmp_id[s] == e_tmp[fptr], "R5 temp index",
                  int'(slot_tmp_id[s]), int'(e_tmp[fptr]));
            if (slot_tmp_wr[s]) begin
              ld_fires++;
              chk(!live[slot_tmp_id[s]], "R5 temp double use", 1, 0);
              live[slot_tmp_id[s]] = 1'b1;
              p_ldcyc[ii] = cyc;
              if (s < DW - 1) chk(!slot_valid[s+1], "R3 load half not last", 1, 0);
            end
            if (slot_tmp_rd[s]) begin
              chk(cyc > p_ldcyc[ii] && s == 0, "R3 ALU half placement", cyc, p_ldcyc[ii] + 1);
              rq[rq_t % 64] = slot_tmp_id[s]; rq_t++;
            end
            fptr++;
          end
        end
      end
    end
    tk = int'(in_take);
    last_take = tk;
    for (int l = 0; l < tk; l++) begin
      if (p_kind[head+l] == 2'b10) begin
        int f = lowest_free(m_busy);
        chk(f >= 0, "R6 fused taken with empty pool", f, 0);
        if (f >= 0) begin
          m_busy[f] = 1'b1;
          e_tmp[p_uop[head+l]] = TMP_W'(f);
          e_tmp[p_uop[head+l] + 1] = TMP_W'(f);
        end
      end
    end
    head += tk;
    if (rel >= 0) begin
      m_busy[rel] = 1'b0;
      live[rel] = 1'b0;
    end
  endtask

  task automatic drain();
    while (fptr < e_len || head < p_len || (rel_en && rq_h != rq_t)) step();
  endtask

  always @(posedge clk) begin
    if (cyc > WD_LIM) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIM);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base_ld, base_head, r;
    void'($urandom(32'h5eed_1234));
    in_valid = '0; in_kind = '0; in_rob = '0; in_base = '0; in_src0 = '0;
    in_src1 = '0; in_src2 = '0; in_dst = '0; mem_ready = 1'b1; alu_ready = 1'b1;
    tmp_rel_valid = 1'b0; tmp_rel_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    chk(slot_valid == '0 && !mem_valid && !alu_valid, "R10 reset outputs",
        int'(slot_valid), 0);

    // directed packing R4 R3 R9
    add_inst(2'b00); add_inst(2'b00); add_inst(2'b01); add_inst(2'b10);
    add_inst(2'b00); add_inst(2'b00); add_inst(2'b00);
    step(); chk(last_take == 2, "R4 two plain lanes into empty stage", last_take, 2);
    step(); chk(last_take == 2, "R4 load plus fused", last_take, 2);
    chk(alu_valid && !mem_valid, "R9 ALU-only group", int'({mem_valid, alu_valid}), 1);
    step(); chk(last_take == 1, "R3 R4 pending half takes slot 0", last_take, 1);
    chk(mem_valid && !alu_valid && slot_tmp_wr[1], "R9 R3 load group", int'({mem_valid, alu_valid}), 2);
    step(); chk(last_take == 2, "R4 after half placed", last_take, 2);
    chk(slot_tmp_rd[0] && alu_valid && !mem_valid, "R3 half in slot 0", int'(slot_tmp_rd), 1);
    drain();

    // back-pressure R8
    add_inst(2'b01); add_inst(2'b00); add_inst(2'b00);
    f_mem = 0;
    step(); chk(last_take == 2, "R8 group loads", last_take, 2);
    step(); chk(last_take == 0, "R8 held group takes nothing", last_take, 0);
    step(); chk(last_take == 0 && slot_valid == 2'b11 && slot_is_load[0],
                "R8 group unchanged", int'(slot_valid), 3);
    f_mem = 1;
    drain();

    // pool exhaustion R6 R7
    rel_en = 0; base_ld = ld_fires; base_head = head;
    for (int i = 0; i < TMP_N + 1; i++) add_inst(2'b10);
    add_inst(2'b00);
    for (int i = 0; i < 40; i++) step();
    chk(ld_fires - base_ld == TMP_N, "R6 loads fired with full pool", ld_fires - base_ld, TMP_N);
    chk(head - base_head == TMP_N, "R6 fused stalls at empty pool", head - base_head, TMP_N);
    chk(last_take == 0, "R6 nothing taken while empty", last_take, 0);
    rel_en = 1;
    drain();
    chk(ld_fires - base_ld == TMP_N + 1, "R7 stalled fused completes after release",
        ld_fires - base_ld, TMP_N + 1);

    // plain lane ahead of a blocked fused lane R6
    rel_en = 0; base_head = head;
    for (int i = 0; i < TMP_N; i++) add_inst(2'b10);
    add_inst(2'b00); add_inst(2'b10);
    for (int i = 0; i < 40; i++) step();
    chk(head - base_head == TMP_N + 1, "R6 older plain lane accepted", head - base_head, TMP_N + 1);
    rel_en = 1;
    drain();

    // random mix
    rdy_rand = 1; lane_rand = 1;
    for (int i = 0; i < 1500; i++) begin
      r = int'($urandom % 100);
      add_inst(r < 38 ? 2'b00 : r < 62 ? 2'b01 : r < 95 ? 2'b10 : 2'b11);
    end
    drain();
    rdy_rand = 0;
    repeat (3) step();
    chk(fptr == e_len, "R2 all micro-ops delivered", fptr, e_len);
    chk(m_busy == '0 && live == '0, "R7 pool empty at end", int'(m_busy), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule